// File: doc/BRIEF.md
# Wide-Range Integer Clock Divider

This block derives a slower clock from its parent clock by an integer ratio of 2 to 65535. One 32-bit control register holds all of its state. The ratio sits in the upper half of the register. The two lowest bits enable the divide counter and gate the output. A small command port acts on the register. Each command is one of four operations:

- a raw write of all 32 bits;
- an enable that keeps the ratio and sets both control bits;
- a stop that clears the whole register;
- a rate load that writes a ratio and clears the control bits.

The enable and rate-load operations follow guarded rules. Enable does nothing when the stored ratio is too small. A rate load with a ratio below 2 clears the register completely.

A ratio of 0 or 1 does not run the counter. With both control bits set, the output then follows the parent clock unchanged. A ratio change made while the divider runs takes effect only at the next output period boundary, so the output period never becomes shorter or longer than one of the two ratios. A status output reports whether the block is actively dividing.

Top module: `clkdiv_top`

## Requirements
- R1: While the reset is asserted and right after it, the register reads zero, `running` is 0 and `clkOut` is 0.
- R2: The raw write operation (`cmdOp` = 0) stores all 32 bits of `cmdData`, and `rdData` returns them.
- R3: The enable operation (`cmdOp` = 1) applies when the ratio field, bits 31:16, is 2 or more. It keeps that field, forces bits 1:0 to 1 and clears bits 15:2.
- R4: The enable operation leaves the register unchanged when the ratio field is 0 or 1.
- R5: The stop operation (`cmdOp` = 2) clears the whole register to zero.
- R6: The rate-load operation (`cmdOp` = 3) takes the ratio N from `cmdData` bits 15:0. For N of 2 or more, the register becomes N in bits 31:16 with zeros below. For N of 0 or 1, the whole register becomes zero.
- R7: `running` is 1 exactly when bits 1:0 are both 1 and the ratio field is 2 or more.
- R8: While dividing by N, `clkOut` has a period of N parent cycles and is high for the first ceil(N/2) of them. Its first rising edge follows the parent edge after the edge that made `running` true.
- R9: `clkOut` stays low when either of bits 1:0 is 0.
- R10: Writing a new ratio while dividing leaves the current output period at the old length. The next period uses the new ratio.
- R11: With bits 1:0 both 1 and a ratio field of 0 or 1, `clkOut` follows the parent clock, and `running` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Apply the operation on this cycle |
| cmdOp | input | 2 | 0 raw write, 1 enable, 2 stop, 3 rate load |
| cmdData | input | 32 | Write value, or the ratio in bits 15:0 for a rate load |
| rdData | output | 32 | Current register value |
| clkOut | output | 1 | Divided or passed-through clock |
| running | output | 1 | Divider active with a ratio of 2 or more |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a running output period. The new value must be held back until the counter wraps. To get there, the stimulus waits until it sees the first high sample of a period, then issues a raw write of a different ratio with both control bits set. It then counts the remaining cycles of that period against the old ratio and measures the following period against the new one. The bypass path is also hard to observe, because its output changes on both parent edges. It is sampled just after each edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W = 32;
  localparam int DIV_W = 16;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_ENABLE = 2'd1,
    OP_STOP   = 2'd2,
    OP_SETDIV = 2'd3
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [DIV_W-1:0] divisor;
    logic             runDiv;
    logic             runBypass;
  } divCtl_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [RW-1:0] cmdData,
  output logic [RW-1:0] regOut,
  output divCtl_t       ctl
);
  localparam int LOW_W = RW - DW;

  logic [RW-1:0] regQ, regNext;
  logic [DW-1:0] divField, argDiv;
  logic          divLarge, argLarge, bothEn;
  cmdOp_e        opSel;

  assign opSel    = cmdOp_e'(cmdOp);
  assign divField = regQ[RW-1:LOW_W];
  assign argDiv   = cmdData[DW-1:0];
  assign divLarge = divField >= DW'(2);
  assign argLarge = argDiv >= DW'(2);
  assign bothEn   = regQ[1] & regQ[0];

  always_comb begin
    regNext = regQ;
    if (cmdValid) begin
      unique case (opSel)
        OP_WRITE:  regNext = cmdData;
        OP_ENABLE: if (divLarge) regNext = {divField, {(LOW_W-2){1'b0}}, 2'b11};
        OP_STOP:   regNext = '0;
        OP_SETDIV: regNext = argLarge ? {argDiv, {LOW_W{1'b0}}} : '0;
        default:   regNext = regQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end

  assign regOut        = regQ;
  assign ctl.divisor   = divField;
  assign ctl.runDiv    = bothEn & divLarge;
  assign ctl.runBypass = bothEn & ~divLarge;

  p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && opSel == OP_STOP |=> regQ == '0);
  p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && opSel == OP_ENABLE && !divLarge |=> $stable(regQ));
  p_enable_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && opSel == OP_ENABLE && divLarge |=>
      regQ[1:0] == 2'b11 && regQ[RW-1:LOW_W] == $past(regQ[RW-1:LOW_W]));
  p_setdiv_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && opSel == OP_SETDIV |=> regQ[LOW_W-1:0] == '0);
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  output logic    clkOut
);
  logic          active, divQ, gateQ, lastCnt;
  logic [DW-1:0] cnt, curDiv, hiLen, cntInc;

  assign lastCnt = (cnt == curDiv - DW'(1));
  assign hiLen   = curDiv - (curDiv >> 1);
  assign cntInc  = cnt + DW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      divQ   <= 1'b0;
      cnt    <= '0;
      curDiv <= DW'(2);
    end else if (!ctl.runDiv) begin
      active <= 1'b0;
      divQ   <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      active <= 1'b1;
      divQ   <= 1'b1;
      cnt    <= '0;
      curDiv <= ctl.divisor;
    end else if (lastCnt) begin
      divQ   <= 1'b1;
      cnt    <= '0;
      curDiv <= ctl.divisor;
    end else begin
      cnt    <= cntInc;
      divQ   <= cntInc < hiLen;
    end
  end

  // gate enable changes only while the parent clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b0;
    else       gateQ <= ctl.runBypass;
  end

  assign clkOut = divQ | (clk & gateQ);

  p_wrap_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    active && ctl.runDiv && lastCnt |=> divQ);
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    active |-> cnt < curDiv);
  p_hold_div_r10: assert property (@(posedge clk) disable iff (!rstN)
    active && ctl.runDiv && !lastCnt |=> $stable(curDiv));
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [RW-1:0] cmdData,
  output logic [RW-1:0] rdData,
  output logic          clkOut,
  output logic          running
);
  divCtl_t ctl;

  clkdiv_ctrl #(.RW(RW), .DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .regOut(rdData), .ctl(ctl)
  );

  clkdiv_datapath #(.DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkOut(clkOut)
  );

  assign running = ctl.runDiv;

  p_running_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    running |-> rdData[RW-1:RW-DW] >= DW'(2));
endmodule

// File: tb/clkdiv_top_test.sv
`timescale 1ns/1ps
module clkdiv_top_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [31:0] cmdData;
  logic [31:0] rdData;
  logic        clkOut, running;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkdiv_top uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .rdData(rdData), .clkOut(clkOut), .running(running)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelNext(logic [31:0] cur, logic [1:0] op, logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return (cur[31:16] >= 16'd2) ? {cur[31:16], 14'd0, 2'b11} : cur;
      2'd2: return 32'd0;
      default: return (d[15:0] >= 16'd2) ? {d[15:0], 16'd0} : 32'd0;
    endcase
  endfunction

  function automatic logic modelRun(logic [31:0] r);
    return r[1] && r[0] && (r[31:16] >= 16'd2);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic doCmd(logic [1:0] op, logic [31:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // starts at the first high sample of a period, ends at the next one
  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (clkOut && hi < 2000) begin hi++; @(negedge clk); end
    while (!clkOut && lo < 2000) begin lo++; @(negedge clk); end
  endtask

  task automatic runDivided(int n);
    int hi, lo;
    doCmd(2'd2, 32'd0);
    doCmd(2'd3, 32'(n));
    doCmd(2'd1, 32'd0);
    check("R8 first edge low", 32'(clkOut), 32'd0);
    check("R7 running", 32'(running), 32'd1);
    @(negedge clk);
    check("R8 first edge high", 32'(clkOut), 32'd1);
    for (int p = 0; p < 2; p++) begin
      measure(hi, lo);
      check("R8 high length", 32'(hi), 32'(n - n / 2));
      check("R8 low length", 32'(lo), 32'(n / 2));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] expReg;
    int hi, lo, rem, n1, n2;
    void'($urandom(32'd4711));
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; cmdData = 32'd0;
    repeat (3) @(negedge clk);
    check("R1 reg", rdData, 32'd0);
    check("R1 running", 32'(running), 32'd0);
    check("R1 clkOut", 32'(clkOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reg after release", rdData, 32'd0);

    doCmd(2'd0, 32'hA5A5_3C3C);
    check("R2 raw write", rdData, 32'hA5A5_3C3C);
    check("R7 low bits clear", 32'(running), 32'd0);
    doCmd(2'd2, 32'hFFFF_FFFF);
    check("R5 stop", rdData, 32'd0);
    doCmd(2'd3, 32'hFFFF_0001);
    check("R6 small ratio", rdData, 32'd0);
    doCmd(2'd3, 32'h0000_FFFF);
    check("R6 max ratio", rdData, 32'hFFFF_0000);
    doCmd(2'd0, 32'hFFFF_00F4);
    doCmd(2'd1, 32'd0);
    check("R3 enable", rdData, 32'hFFFF_0003);
    check("R7 running max", 32'(running), 32'd1);
    doCmd(2'd0, 32'h0001_0004);
    doCmd(2'd1, 32'd0);
    check("R4 ratio one", rdData, 32'h0001_0004);
    doCmd(2'd0, 32'h0000_0000);
    doCmd(2'd1, 32'd0);
    check("R4 ratio zero", rdData, 32'd0);

    // R9: one control bit only
    for (int b = 1; b <= 2; b++) begin
      doCmd(2'd0, {16'd4, 14'd0, 2'(b)});
      for (int k = 0; k < 8; k++) begin
        check("R9 output low", 32'(clkOut), 32'd0);
        @(negedge clk);
      end
      check("R7 partial enable", 32'(running), 32'd0);
    end

    // R8 directed and random ratios
    runDivided(2);
    runDivided(3);
    runDivided(7);
    for (int t = 0; t < 5; t++) runDivided(2 + int'($urandom % 39));

    // R10 ratio change in the middle of a period
    for (int t = 0; t < 3; t++) begin
      n1 = 3 + int'($urandom % 20);
      n2 = 2 + int'($urandom % 20);
      runDivided(n1);
      doCmd(2'd0, {16'(n2), 14'd0, 2'b11});
      rem = 0;
      while (clkOut && rem < 2000) begin rem++; @(negedge clk); end
      while (!clkOut && rem < 4000) begin rem++; @(negedge clk); end
      check("R10 old period kept", 32'(rem), 32'(n1 - 1));
      measure(hi, lo);
      check("R10 new period", 32'(hi + lo), 32'(n2));
    end

    // R11 bypass
    doCmd(2'd0, {16'd1, 14'd0, 2'b11});
    repeat (2) @(negedge clk);
    check("R11 running", 32'(running), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check("R11 follows high", 32'(clkOut), 32'd1);
      @(negedge clk); #1;
      check("R11 follows low", 32'(clkOut), 32'd0);
    end
    @(negedge clk);
    doCmd(2'd0, {16'd0, 14'd0, 2'b01});
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    check("R9 bypass gated", 32'(clkOut), 32'd0);
    @(negedge clk);

    // random register operations
    doCmd(2'd2, 32'd0);
    expReg = 32'd0;
    for (int t = 0; t < 40; t++) begin
      logic [1:0]  op;
      logic [31:0] d;
      op = 2'($urandom % 4);
      d  = $urandom;
      if ($urandom % 3 == 0) d[31:16] = 16'($urandom % 2);
      if ($urandom % 3 == 0) d[15:0]  = 16'($urandom % 3);
      expReg = modelNext(expReg, op, d);
      doCmd(op, d);
      case (op)
        2'd0: check("R2 random write", rdData, expReg);
        2'd1: check("R3 R4 random enable", rdData, expReg);
        2'd2: check("R5 random stop", rdData, expReg);
        default: check("R6 random rate load", rdData, expReg);
      endcase
      check("R7 random running", 32'(running), 32'(modelRun(expReg)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule